// File: doc/BRIEF.md
# UART Receive Buffer with Status Flags

This block is the receive-side store of a UART. A deserializer hands it characters through a push port. Each character is 12 bits wide: eight data bits, and above them four error bits. A separate break strobe stores a break marker instead of the character data. Entries sit in a circular buffer and leave it in arrival order. The head entry is always visible on the read-data port. A data-register read strobe advances the buffer and copies the error bits of the entry just read into a status register.

A control input selects buffered mode, with room for 16 entries, or single-character mode, with room for one. Any change of that input flushes the buffer. The block keeps an empty flag and a full flag, and raises an interrupt request whenever at least one character is waiting, since the trigger level is one. A ready output tells the deserializer whether a push will be accepted.

Top module: `rx_fifo`

## Requirements
- R1: After reset, emptyFlag is 1, fullFlag is 0, rxIrq is 0, rxStatus is 0 and pushReady is 1.
- R2: With fifoEn at 1, pushReady is 1 while fewer than 16 entries are held. Entries are read back in push order, also across the wrap of the storage index. fullFlag rises when the sixteenth entry is stored.
- R3: With fifoEn at 0, the block holds at most one entry. A push sets fullFlag and drops pushReady until that entry is read.
- R4: A push offered while pushReady is 0 is dropped. It changes no flag and no stored entry.
- R5: rdData always shows the head entry. A read strobe with entries held removes the head and clears fullFlag, and emptyFlag is set once the last entry leaves. A read with nothing held moves nothing, and emptyFlag stays 1.
- R6: Entry bit 8 is framing error, bit 9 parity error, bit 10 break and bit 11 overrun. On every read strobe, rxStatus takes bits 11:8 of the rdData shown in that cycle. Without a read strobe, rxStatus holds its value.
- R7: A push with pushBreak at 1 stores the value 0x400 (break bit only), whatever pushData carries.
- R8: rxIrq rises when a push brings the count to 1. It falls when a read brings the count to 0. Because the trigger level is one, rxIrq always equals the inverse of emptyFlag.
- R9: In a cycle where fifoEn differs from its value in the previous cycle, the buffer is flushed and pushReady is 0, so any push is dropped. Afterwards emptyFlag is 1, fullFlag is 0 and rxIrq is 0.
- R10: A push and a read in the same cycle both take effect. The head leaves, the new entry joins the tail, and the count is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| fifoEn | input | 1 | 1 selects 16-entry buffering, 0 selects single-entry mode |
| pushValid | input | 1 | Deserializer offers an entry |
| pushBreak | input | 1 | The offered push is a break marker |
| pushData | input | 12 | Received entry: data 7:0, error bits 11:8 |
| pushReady | output | 1 | A push in this cycle will be accepted |
| rdStrobe | input | 1 | Data-register read |
| rdData | output | 12 | Head entry |
| rxStatus | output | 4 | Error bits latched by the last read |
| emptyFlag | output | 1 | Nothing held |
| fullFlag | output | 1 | No room for another entry |
| rxIrq | output | 1 | Receive interrupt request |

## Verification
A push and a read can fall in the same cycle. So can a mode change and either of them. The bench provokes both pairings on purpose: it streams paired push and read cycles against a partly filled buffer, and it toggles fifoEn while pushes and reads are pending. It also runs a long mixed stretch where all three happen at random. A behavioural queue model judges every cycle: the count must stay put under a pair, and a flush must override both the push and the pointer move, while the read still latches status.

// File: rtl/rx_fifo_pkg.sv
`timescale 1ns/1ps
package rx_fifo_pkg;
  localparam int DATA_W = 8;
  localparam int ERR_W  = 4;
  localparam int ENT_W  = DATA_W + ERR_W;
  // break sits two bits above the data field (framing, parity, break, overrun)
  localparam logic [ENT_W-1:0] BREAK_ENTRY = ENT_W'(1) << (DATA_W + 2);

  typedef struct packed {
    logic wrEn;    // store the offered entry
    logic rdLatch; // copy head error bits into status
  } rxStrobe_t;
endpackage

// File: rtl/rxfifo_ctrl.sv
`timescale 1ns/1ps
module rxfifo_ctrl
  import rx_fifo_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             fifoEn,
  input  logic             pushValid,
  input  logic             rdStrobe,
  output rxStrobe_t        strb,
  output logic [PTR_W-1:0] wrIdx,
  output logic [PTR_W-1:0] rdIdx,
  output logic             pushReady,
  output logic             emptyFlag,
  output logic             fullFlag,
  output logic             rxIrq
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] ONE_CNT  = CNT_W'(1);
  localparam logic [CNT_W-1:0] TRIG_CNT = CNT_W'(1);

  logic [PTR_W-1:0] rdPtr;
  logic [CNT_W-1:0] count, countNext, limit;
  logic             fifoEnQ, modeFlip, pushAcc, popAcc;
  logic             emptyQ, fullQ, irqQ;
  logic [PTR_W:0]   slotSum;

  assign modeFlip  = fifoEn ^ fifoEnQ;
  assign limit     = fifoEn ? FULL_CNT : ONE_CNT;
  assign pushReady = !modeFlip && (count < limit);
  assign pushAcc   = pushValid && pushReady;
  assign popAcc    = rdStrobe && !modeFlip && (count != '0);
  assign countNext = count + CNT_W'(pushAcc) - CNT_W'(popAcc);

  assign slotSum = (PTR_W+1)'(rdPtr) + (PTR_W+1)'(count);
  assign wrIdx   = (slotSum >= (PTR_W+1)'(DEPTH)) ? PTR_W'(slotSum - (PTR_W+1)'(DEPTH))
                                                  : PTR_W'(slotSum);
  assign rdIdx   = rdPtr;

  assign strb.wrEn    = pushAcc;
  assign strb.rdLatch = rdStrobe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdPtr   <= '0;
      count   <= '0;
      fifoEnQ <= 1'b0;
      emptyQ  <= 1'b1;
      fullQ   <= 1'b0;
      irqQ    <= 1'b0;
    end else begin
      fifoEnQ <= fifoEn;
      if (modeFlip) begin
        rdPtr  <= '0;
        count  <= '0;
        emptyQ <= 1'b1;
        fullQ  <= 1'b0;
        irqQ   <= 1'b0;
      end else begin
        count  <= countNext;
        emptyQ <= (countNext == '0);
        if (popAcc)
          rdPtr <= (rdPtr == PTR_W'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
        if (pushAcc)
          fullQ <= !fifoEn || (countNext == FULL_CNT);
        else if (rdStrobe)
          fullQ <= 1'b0;
        if (pushAcc && countNext == TRIG_CNT)
          irqQ <= 1'b1;
        else if (popAcc && countNext == TRIG_CNT - 1'b1)
          irqQ <= 1'b0;
      end
    end
  end

  assign emptyFlag = emptyQ;
  assign fullFlag  = fullQ;
  assign rxIrq     = irqQ;
endmodule

// File: rtl/rxfifo_dp.sv
`timescale 1ns/1ps
module rxfifo_dp
  import rx_fifo_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  rxStrobe_t        strb,
  input  logic [PTR_W-1:0] wrIdx,
  input  logic [PTR_W-1:0] rdIdx,
  input  logic             pushBreak,
  input  logic [ENT_W-1:0] pushData,
  output logic [ENT_W-1:0] rdData,
  output logic [ERR_W-1:0] rxStatus
);
  logic [ENT_W-1:0] mem [DEPTH];
  logic [ENT_W-1:0] wrEntry;
  logic [ERR_W-1:0] statusQ;

  assign wrEntry = pushBreak ? BREAK_ENTRY : pushData;
  assign rdData  = mem[rdIdx];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (strb.wrEn) begin
      mem[wrIdx] <= wrEntry;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             statusQ <= '0;
    else if (strb.rdLatch) statusQ <= rdData[ENT_W-1:DATA_W];
  end

  assign rxStatus = statusQ;
endmodule

// File: rtl/rx_fifo.sv
`timescale 1ns/1ps
module rx_fifo
  import rx_fifo_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             fifoEn,
  input  logic             pushValid,
  input  logic             pushBreak,
  input  logic [11:0]      pushData,
  output logic             pushReady,
  input  logic             rdStrobe,
  output logic [11:0]      rdData,
  output logic [3:0]       rxStatus,
  output logic             emptyFlag,
  output logic             fullFlag,
  output logic             rxIrq
);
  localparam int PTR_W = $clog2(DEPTH);

  rxStrobe_t        strb;
  logic [PTR_W-1:0] wrIdx, rdIdx;

  rxfifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .fifoEn(fifoEn), .pushValid(pushValid),
    .rdStrobe(rdStrobe), .strb(strb), .wrIdx(wrIdx), .rdIdx(rdIdx),
    .pushReady(pushReady), .emptyFlag(emptyFlag), .fullFlag(fullFlag),
    .rxIrq(rxIrq)
  );

  rxfifo_dp #(.DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrIdx(wrIdx), .rdIdx(rdIdx),
    .pushBreak(pushBreak), .pushData(pushData), .rdData(rdData),
    .rxStatus(rxStatus)
  );
endmodule

// File: rtl/rx_fifo_chk.sv
`timescale 1ns/1ps
module rx_fifo_chk (
  input logic       clk,
  input logic       rstN,
  input logic       fifoEn,
  input logic       pushValid,
  input logic       pushReady,
  input logic       rdStrobe,
  input logic [3:0] rxStatus,
  input logic       emptyFlag,
  input logic       fullFlag,
  input logic       rxIrq
);
  logic enSeen;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) enSeen <= 1'b0;
    else       enSeen <= fifoEn;
  end

  // R2
  full_no_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    fullFlag |-> !pushReady);
  // R5
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(emptyFlag && fullFlag));
  // R8
  irq_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxIrq == !emptyFlag);
  // R6
  status_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rdStrobe |=> $stable(rxStatus));
  // R5
  push_fills_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pushValid && pushReady && !rdStrobe) |=> !emptyFlag);
  // R3
  single_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!fifoEn && pushValid && pushReady) |=> fullFlag);
  // R9
  flush_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fifoEn != enSeen) |-> !pushReady);
  // R9
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fifoEn != enSeen) |=> (emptyFlag && !fullFlag));
endmodule

bind rx_fifo rx_fifo_chk u_chk (
  .clk(clk), .rstN(rstN), .fifoEn(fifoEn), .pushValid(pushValid),
  .pushReady(pushReady), .rdStrobe(rdStrobe), .rxStatus(rxStatus),
  .emptyFlag(emptyFlag), .fullFlag(fullFlag), .rxIrq(rxIrq)
);

// File: tb/rx_fifo_tb.sv
`timescale 1ns/1ps
module rx_fifo_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic fifoEn = 1'b0, pushValid = 1'b0, pushBreak = 1'b0, rdStrobe = 1'b0;
  logic [11:0] pushData = '0;
  logic pushReady, emptyFlag, fullFlag, rxIrq;
  logic [11:0] rdData;
  logic [3:0]  rxStatus;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  // behavioural reference state
  logic [11:0] q[$];
  bit enPrev = 1'b0, mEmpty = 1'b1, mFull = 1'b0, mIrq = 1'b0, statusKnown = 1'b1;
  logic [3:0] mStatus = '0;

  always #2.5 clk = ~clk;

  rx_fifo u_dut (
    .clk(clk), .rstN(rstN), .fifoEn(fifoEn), .pushValid(pushValid),
    .pushBreak(pushBreak), .pushData(pushData), .pushReady(pushReady),
    .rdStrobe(rdStrobe), .rdData(rdData), .rxStatus(rxStatus),
    .emptyFlag(emptyFlag), .fullFlag(fullFlag), .rxIrq(rxIrq)
  );

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  // one clock: drive after negedge, check combinational outputs, then model the edge
  task automatic cyc(input string tag, input bit p, input bit b, input logic [11:0] d,
                     input bit r, input bit e);
    bit flip, rdy, popped;
    int sz;
    pushValid = p; pushBreak = b; pushData = d; rdStrobe = r; fifoEn = e;
    #1;
    sz   = q.size();
    flip = (e != enPrev);
    rdy  = !flip && (e ? (sz < 16) : (sz == 0));
    chk({tag, " R4 pushReady"}, pushReady, rdy);
    if (r && sz > 0) chk({tag, " R5 rdData"}, rdData, q[0]);
    @(posedge clk);
    if (r) begin
      statusKnown = (sz > 0);
      if (sz > 0) mStatus = q[0][11:8];
    end
    enPrev = e;
    if (flip) begin
      q.delete(); mEmpty = 1; mFull = 0; mIrq = 0;
    end else begin
      popped = r && sz > 0;
      if (popped) void'(q.pop_front());
      if (p && rdy) begin
        q.push_back(b ? 12'h400 : d);
        mFull = !e || (q.size() == 16);
        if (q.size() == 1) mIrq = 1;
      end else if (r) mFull = 0;
      if (popped && q.size() == 0) mIrq = 0;
      mEmpty = (q.size() == 0);
    end
    @(negedge clk);
    chk({tag, " R5 emptyFlag"}, emptyFlag, mEmpty);
    chk({tag, " R2/R3 fullFlag"}, fullFlag, mFull);
    chk({tag, " R8 rxIrq"}, rxIrq, mIrq);
    if (statusKnown) chk({tag, " R6 rxStatus"}, rxStatus, mStatus);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1 reset state
    chk("R1 emptyFlag", emptyFlag, 1);
    chk("R1 fullFlag", fullFlag, 0);
    chk("R1 rxIrq", rxIrq, 0);
    chk("R1 rxStatus", rxStatus, 0);
    chk("R1 pushReady", pushReady, 1);
    @(negedge clk);

    // enter buffered mode (R9 flush of an empty buffer)
    cyc("R9 enter", 0, 0, 0, 0, 1);
    // R2 fill to 16 with varied error bits
    for (int i = 0; i < 16; i++) cyc("R2 fill", 1, 0, 12'((i * 37) ^ (i << 8)), 0, 1);
    chk("R2 full at 16", fullFlag, 1);
    cyc("R4 drop", 1, 0, 12'hABC, 0, 1);
    for (int i = 0; i < 5; i++) cyc("R5 drain", 0, 0, 0, 1, 1);
    for (int i = 0; i < 5; i++) cyc("R2 wrap", 1, 0, 12'(12'h100 * i + 12'h5A), 0, 1);
    for (int i = 0; i < 17; i++) cyc("R5 empty", 0, 0, 0, 1, 1);
    chk("R5 empty after drain", emptyFlag, 1);

    // R7 break marker
    cyc("R7 brk", 1, 1, 12'hFFF, 0, 1);
    #1 chk("R7 break entry", rdData, 12'h400);
    cyc("R7 rd", 0, 0, 0, 1, 1);
    chk("R7 status break bit", rxStatus, 4'h4);

    // R10 paired push and read
    for (int i = 0; i < 3; i++) cyc("R10 pre", 1, 0, 12'(12'h210 + i), 0, 1);
    for (int i = 0; i < 6; i++) cyc("R10 pair", 1, 0, 12'(12'h830 + i), 1, 1);
    for (int i = 0; i < 4; i++) cyc("R10 drain", 0, 0, 0, 1, 1);

    // R9 flush with data, push and read during the flip
    for (int i = 0; i < 4; i++) cyc("R9 pre", 1, 0, 12'(12'h300 + i), 0, 1);
    cyc("R9 flip", 1, 0, 12'h3FF, 1, 0);
    chk("R9 flushed empty", emptyFlag, 1);
    chk("R9 irq low", rxIrq, 0);

    // R3 single-entry mode
    cyc("R3 push", 1, 0, 12'h941, 0, 0);
    chk("R3 full one", fullFlag, 1);
    cyc("R3 drop", 1, 0, 12'h042, 0, 0);
    cyc("R3 rd", 0, 0, 0, 1, 0);
    cyc("R3 pair", 1, 0, 12'hC43, 1, 0);
    cyc("R3 rd2", 0, 0, 0, 1, 0);

    // mixed traffic
    for (int i = 0; i < 3000; i++) begin
      automatic int rv = $urandom;
      automatic bit en = (rv[9:0] == 0) ? !fifoEn : fifoEn;
      cyc("R10 mix", rv[12] | rv[13], rv[14] & rv[15] & rv[16], 12'(rv >>> 17),
          rv[18] & rv[19], en);
    end

    done = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule